// File: doc/BRIEF.md
# Snapshot Event Counter Bank

This peripheral sits on a byte-wide processor bus. It keeps five 64-bit counters that always run: elapsed clock cycles, retired instructions, serviced maskable interrupts, serviced non-maskable interrupts, and a wall-clock time in nanoseconds since the start of 1970. The wall-clock counter has no real-time source inside the block. Each clock it advances by a fixed step, and it can be preset through a dedicated load port.

Software freezes every counter at once by writing to a snapshot address. The frozen copies are then read one byte at a time through an eight-byte window. A select register picks which frozen copy the window shows. Because the copies change only on a snapshot write, a value read over several bus accesses always comes from one instant and never mixes bytes from different moments.

Top module: `evt_snapshot_bank`

## Requirements
- R1: After reset, all live counters, all snapshot copies and the select register are zero, and read data is zero.
- R2: The cycle counter advances by one every clock. The nanosecond counter advances by NS_PER_CLK every clock. Both wrap modulo 2^64.
- R3: The instruction, interrupt and non-maskable-interrupt counters each advance by one in every cycle in which their strobe input is high.
- R4: A write to address 0x00 copies all five live counters into their snapshot copies in the same cycle, whatever the data byte is. A strobe in that same cycle is counted in the live counter, but the copy takes the value from before the increment.
- R5: A write to address 0x01 stores the data byte as the select value. A read of 0x01 returns the stored byte.
- R6: Addresses 0x02 to 0x09 form the window. Address 0x02+k returns bits 8k+7:8k of the snapshot chosen by the select value. The select codes are 0 for cycles, 1 for instructions, 2 for interrupts, 3 for non-maskable interrupts and 4 for wall-clock.
- R7: With a select value of 5 or more, every window address reads as zero.
- R8: Writes to any address other than 0x00 and 0x01 change nothing. Reads from any address other than 0x01 and 0x02 to 0x09 return zero.
- R9: If time_valid is low in the cycle of a snapshot write, the wall-clock snapshot becomes all ones.
- R10: A cycle with time_load high sets the nanosecond counter to time_load_val on that clock edge.
- R11: Read data is registered. It shows the result of a read strobe one cycle later, and it is zero in the cycle after any cycle without a read strobe.
- R12: The snapshot copies keep their values until the next snapshot write, however the live counters move in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| instr_retired | input | 1 | One-cycle pulse per retired instruction |
| irq_taken | input | 1 | One-cycle pulse per serviced interrupt |
| nmi_taken | input | 1 | One-cycle pulse per serviced non-maskable interrupt |
| time_load | input | 1 | Preset strobe for the nanosecond counter |
| time_load_val | input | 64 | Preset value for the nanosecond counter |
| time_valid | input | 1 | Low marks the time source as failed |

## Verification
A fault in a live counter stays hidden until the next snapshot write. After that write it shows up as a wrong byte in one select slot of the window. A fault in the snapshot capture or hold shows up when the window is read again after the live counters have moved on. A fault in the select register or the byte steering shows on the very next window read: either the wrong byte lane or a nonzero value where zero is expected. The bench therefore snapshots, then reads every byte of every slot, and repeats this after more events arrive.

// File: rtl/evt_snap_pkg.sv
package evt_snap_pkg;
    localparam int CNT_W     = 64;
    localparam int NUM_SRC   = 5;
    localparam int NUM_EVT   = 4;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 8;
    localparam int WIN_BYTES = CNT_W / DATA_W;
    localparam int OFF_W     = $clog2(WIN_BYTES);

    localparam logic [ADDR_W-1:0] ADR_SNAP = 8'h00;
    localparam logic [ADDR_W-1:0] ADR_SEL  = 8'h01;
    localparam logic [ADDR_W-1:0] ADR_WIN  = 8'h02;

    typedef enum logic [2:0] {
        SRC_CYC   = 3'd0,
        SRC_INSTR = 3'd1,
        SRC_IRQ   = 3'd2,
        SRC_NMI   = 3'd3,
        SRC_WALL  = 3'd4
    } src_e;

    typedef logic [NUM_SRC-1:0][CNT_W-1:0] bank_t;
endpackage

// File: rtl/evt_live_ctrs.sv
module evt_live_ctrs
    import evt_snap_pkg::*;
#(
    parameter logic [CNT_W-1:0] NS_STEP = 64'd10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_stb,
    input  logic             irq_stb,
    input  logic             nmi_stb,
    input  logic             time_load,
    input  logic [CNT_W-1:0] time_load_val,
    output bank_t            live
);
    bank_t            cnt_d, cnt_q;
    logic [NUM_EVT-1:0] inc;

    // cycle counter always steps; the others step on their strobe
    assign inc = {nmi_stb, irq_stb, instr_stb, 1'b1};

    always_comb begin
        cnt_d = cnt_q;
        for (int i = 0; i < NUM_EVT; i++) begin
            cnt_d[i] = cnt_q[i] + {{(CNT_W-1){1'b0}}, inc[i]};
        end
        if (time_load) cnt_d[SRC_WALL] = time_load_val;
        else           cnt_d[SRC_WALL] = cnt_q[SRC_WALL] + NS_STEP;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign live = cnt_q;

    a_r2_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> cnt_q[SRC_CYC] == $past(cnt_q[SRC_CYC]) + 64'd1);
    a_r3_instr_step: assert property (@(posedge clk) disable iff (!rst_n)
        instr_stb |=> cnt_q[SRC_INSTR] == $past(cnt_q[SRC_INSTR]) + 64'd1);
    a_r3_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_stb |=> $stable(cnt_q[SRC_IRQ]));
    a_r10_preset: assert property (@(posedge clk) disable iff (!rst_n)
        time_load |=> cnt_q[SRC_WALL] == $past(time_load_val));
endmodule

// File: rtl/evt_shadow_bank.sv
module evt_shadow_bank
    import evt_snap_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  snap_stb,
    input  logic  time_valid,
    input  bank_t live,
    output bank_t shadow
);
    bank_t sh_d, sh_q;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
        if (g == int'(SRC_WALL)) begin : g_wall
            // a failed time source freezes as all ones
            always_comb begin
                sh_d[g] = sh_q[g];
                if (snap_stb) sh_d[g] = time_valid ? live[g] : {CNT_W{1'b1}};
            end
        end else begin : g_evt
            always_comb begin
                sh_d[g] = sh_q[g];
                if (snap_stb) sh_d[g] = live[g];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign shadow = sh_q;

    a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
        snap_stb |=> sh_q[SRC_CYC] == $past(live[SRC_CYC]));
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_stb |=> $stable(sh_q));
    a_r9_bad_time: assert property (@(posedge clk) disable iff (!rst_n)
        snap_stb && !time_valid |=> sh_q[SRC_WALL] == {CNT_W{1'b1}});
endmodule

// File: rtl/evt_read_port.sv
module evt_read_port
    import evt_snap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  bank_t             shadow,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic [DATA_W-1:0] sel;
        logic [DATA_W-1:0] rdata;
    } port_t;

    port_t             st_d, st_q;
    logic              in_win;
    logic [OFF_W-1:0]  off;
    logic [CNT_W-1:0]  picked;
    logic [ADDR_W-1:0] win_rel;

    assign win_rel = bus_addr - ADR_WIN;
    assign in_win  = (bus_addr >= ADR_WIN) && (win_rel < ADDR_W'(WIN_BYTES));
    assign off     = win_rel[OFF_W-1:0];

    always_comb begin
        picked = '0;
        if (st_q.sel < DATA_W'(NUM_SRC)) picked = shadow[st_q.sel[2:0]];
    end

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        if (bus_wr && bus_addr == ADR_SEL) st_d.sel = bus_wdata;
        if (bus_rd) begin
            if (bus_addr == ADR_SEL) st_d.rdata = st_q.sel;
            else if (in_win)         st_d.rdata = picked[DATA_W*off +: DATA_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;

    a_r5_sel_store: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == ADR_SEL |=> st_q.sel == $past(bus_wdata));
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> rdata == '0);
    a_r7_bad_sel: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && in_win && st_q.sel >= DATA_W'(NUM_SRC) |=> rdata == '0);
    a_r8_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && !in_win && bus_addr != ADR_SEL |=> rdata == '0);
endmodule

// File: rtl/evt_snapshot_bank.sv
module evt_snapshot_bank
    import evt_snap_pkg::*;
#(
    parameter logic [63:0] NS_PER_CLK = 64'd10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    input  logic        bus_wr,
    input  logic        bus_rd,
    output logic [7:0]  bus_rdata,
    input  logic        instr_retired,
    input  logic        irq_taken,
    input  logic        nmi_taken,
    input  logic        time_load,
    input  logic [63:0] time_load_val,
    input  logic        time_valid
);
    bank_t live, shadow;
    logic  snap_stb;

    assign snap_stb = bus_wr && (bus_addr == ADR_SNAP);

    evt_live_ctrs #(.NS_STEP(NS_PER_CLK)) u_live (
        .clk           (clk),
        .rst_n         (rst_n),
        .instr_stb     (instr_retired),
        .irq_stb       (irq_taken),
        .nmi_stb       (nmi_taken),
        .time_load     (time_load),
        .time_load_val (time_load_val),
        .live          (live)
    );

    evt_shadow_bank u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .snap_stb   (snap_stb),
        .time_valid (time_valid),
        .live       (live),
        .shadow     (shadow)
    );

    evt_read_port u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .shadow    (shadow),
        .rdata     (bus_rdata)
    );
endmodule

// File: tb/evt_snapshot_bank_bench.sv
module evt_snapshot_bank_bench;
    localparam int          CLK_PERIOD = 10;
    localparam logic [63:0] NS_STEP    = 64'd10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0, bus_wdata = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        instr_retired = 1'b0, irq_taken = 1'b0, nmi_taken = 1'b0;
    logic        time_load = 1'b0, time_valid = 1'b1;
    logic [63:0] time_load_val = '0;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_snapshot_bank #(.NS_PER_CLK(NS_STEP)) u_evt_snapshot_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .instr_retired(instr_retired), .irq_taken(irq_taken), .nmi_taken(nmi_taken),
        .time_load(time_load), .time_load_val(time_load_val), .time_valid(time_valid)
    );

    // requirement model of the live counters (R2, R3, R10)
    logic [63:0] m_cyc, m_ins, m_irq, m_nmi, m_ns;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cyc <= '0; m_ins <= '0; m_irq <= '0; m_nmi <= '0; m_ns <= '0;
        end else begin
            m_cyc <= m_cyc + 64'd1;
            m_ins <= m_ins + {63'd0, instr_retired};
            m_irq <= m_irq + {63'd0, irq_taken};
            m_nmi <= m_nmi + {63'd0, nmi_taken};
            m_ns  <= time_load ? time_load_val : m_ns + NS_STEP;
        end
    end

    logic [63:0] exp_snap [5];

    // scoreboard
    logic [7:0] q_exp [$];
    string      q_tag [$];
    logic       rd_seen = 1'b0;

    always @(posedge clk) rd_seen <= bus_rd;

    always @(negedge clk) begin
        if (rd_seen) begin
            logic [7:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                errors++;
                $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
            end
        end
    end

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        q_exp.push_back(e);
        q_tag.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic read_window(input logic [7:0] sel, input logic [63:0] v, input string tag);
        bus_write(8'h01, sel);
        for (int i = 0; i < 8; i++) bus_read(8'h02 + 8'(i), v[8*i +: 8], tag);
    endtask

    task automatic snapshot(input logic [7:0] d, input logic with_instr);
        @(negedge clk);
        exp_snap[0] = m_cyc;
        exp_snap[1] = m_ins;
        exp_snap[2] = m_irq;
        exp_snap[3] = m_nmi;
        exp_snap[4] = time_valid ? m_ns : '1;
        bus_addr = 8'h00; bus_wdata = d; bus_wr = 1'b1;
        instr_retired = with_instr;
        @(negedge clk);
        bus_wr = 1'b0; instr_retired = 1'b0;
    endtask

    task automatic pulses(input int n, input logic [2:0] pat);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            instr_retired = pat[0] | (i % 2 == 0);
            irq_taken     = pat[1] & (i % 3 == 0);
            nmi_taken     = pat[2];
        end
        @(negedge clk);
        instr_retired = 1'b0; irq_taken = 1'b0; nmi_taken = 1'b0;
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(bus_rdata, 8'h00, "R1 rdata after reset");
        bus_read(8'h01, 8'h00, "R1 select after reset");
        for (int i = 0; i < 8; i++) bus_read(8'h02 + 8'(i), 8'h00, "R1 snapshot after reset");

        // R2 R3 R4 R6: events, snapshot, read every slot
        pulses(9, 3'b011);
        pulses(5, 3'b100);
        snapshot(8'hA5, 1'b0);
        read_window(8'd0, exp_snap[0], "R6 R2 cycles");
        read_window(8'd1, exp_snap[1], "R6 R3 instructions");
        read_window(8'd2, exp_snap[2], "R6 R3 irq");
        read_window(8'd3, exp_snap[3], "R6 R3 nmi");
        read_window(8'd4, exp_snap[4], "R6 R2 wallclock");

        // R5 and R11
        bus_write(8'h01, 8'h03);
        bus_read(8'h01, 8'h03, "R5 select readback");
        @(negedge clk);
        chk(bus_rdata, 8'h00, "R11 idle read data");

        // R7 unsupported select
        read_window(8'h05, 64'd0, "R7 select 5");
        read_window(8'hFF, 64'd0, "R7 select FF");

        // R8 ignored writes and unmapped reads
        bus_write(8'h05, 8'hEE);
        bus_write(8'h0A, 8'h77);
        bus_read(8'h01, 8'hFF, "R8 select untouched");
        bus_read(8'h0A, 8'h00, "R8 read past window");
        bus_read(8'hC3, 8'h00, "R8 read high address");
        bus_read(8'h00, 8'h00, "R8 read snapshot address");
        read_window(8'd1, exp_snap[1], "R8 snapshot untouched");

        // R12 hold while live counters move
        pulses(7, 3'b111);
        read_window(8'd3, exp_snap[3], "R12 nmi held");
        read_window(8'd0, exp_snap[0], "R12 cycles held");

        // R4 coincident strobe: pre-increment in snapshot, counted live
        snapshot(8'h00, 1'b1);
        read_window(8'd1, exp_snap[1], "R4 coincident pre-increment");
        snapshot(8'h3C, 1'b0);
        read_window(8'd1, exp_snap[1], "R4 coincident counted live");

        // R10 preset near wrap and R2 wrap
        @(negedge clk);
        time_load = 1'b1; time_load_val = 64'hFFFF_FFFF_FFFF_FFF0;
        @(negedge clk);
        time_load = 1'b0;
        repeat (3) @(negedge clk);
        snapshot(8'h11, 1'b0);
        read_window(8'd4, exp_snap[4], "R10 R2 preset and wrap");

        // R9 failed time source
        time_valid = 1'b0;
        snapshot(8'h22, 1'b0);
        time_valid = 1'b1;
        read_window(8'd4, 64'hFFFF_FFFF_FFFF_FFFF, "R9 time invalid");
        snapshot(8'h33, 1'b0);
        read_window(8'd4, exp_snap[4], "R9 time valid again");
        read_window(8'd0, exp_snap[0], "R2 cycles late");

        repeat (4) @(negedge clk);
        summary();
    end
endmodule